// File: doc/BRIEF.md
# Stuck-At Aware Partitioned Inversion Writer

This block sits between a requester and an array of memory lines whose cells can fail permanently, each failed cell reading back a fixed 0 or 1. Every line is divided into equal partitions, and each partition of each line owns one stored inversion flag. On a write, the block looks up the failed cells it already knows about for the addressed line. Each partition that holds such a cell is stored either as the true data or as its bitwise complement, whichever places the cell's stuck value into that cell. A partition with no known failed cell is stored with the flag it already had.

After every memory write the block reads the line back and compares it with what it meant to store. On a mismatch it records the lowest mismatching position, together with the value read there, in a small fault cache. It then recomputes the flags and writes the line a second time. A fault that is already cached is honoured on the first attempt, so no second write is needed. Reads return the stored line with each partition XORed by its flag, which gives back the true data.

Top module: `stuck_inv_writer`

## Requirements
- R1: After reset, busy, wr_done, wr_err, rd_valid, mem_we and mem_re are low, and every inversion flag is 0. A first write to a line with no known fault therefore places the data unchanged on mem_wdata.
- R2: For a partition holding exactly one cached fault, the flag becomes (data bit at the fault position) XOR (stuck value). The stored partition is then the data XORed with that flag, so the faulty cell is asked for its stuck value.
- R3: A partition with no cached fault for the addressed line keeps the flag it held before the write.
- R4: A read request returns rd_data equal to the line read from memory with every bit of partition p XORed by that line's flag p. rd_valid pulses for one cycle.
- R5: Every memory write is followed in the next cycle by a verify read of the same line. On a mismatch, the lowest mismatching position and the value read there are recorded, and the line is written once more with recomputed flags (two memory writes in total).
- R6: A write whose faults are all already cached completes with a single memory write and wr_err low.
- R7: wr_err is high while wr_done pulses if a partition holds two cached faults that need different flags, or if the verify after the second write still mismatches. When two cached faults disagree, the fault in the lower cache entry sets the flag.
- R8: The fault cache holds FC_ENTRIES entries, filled and then overwritten in round-robin order. A fault whose entry has been overwritten no longer affects the flags.
- R9: A wr_req or rd_req that arrives while busy is high is ignored. It causes no memory write and changes no stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Start a write (accepted only when not busy) |
| wr_addr | input | ADDR_W | Line index for the write |
| wr_data | input | LINE_W | True data to store |
| rd_req | input | 1 | Start a read (write wins if both are high) |
| rd_addr | input | ADDR_W | Line index for the read |
| busy | output | 1 | An operation is in progress |
| wr_done | output | 1 | One-cycle pulse at the end of a write |
| wr_err | output | 1 | Write could not be made fault-free; valid with wr_done |
| rd_valid | output | 1 | One-cycle pulse, rd_data valid |
| rd_data | output | LINE_W | Decoded true data of the read line |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data expected on mem_rdata one cycle later |
| mem_addr | output | ADDR_W | Memory line index |
| mem_wdata | output | LINE_W | Encoded line to store |
| mem_rdata | input | LINE_W | Line read from memory |

## Verification
A fault-free line shows that a write passes data through unchanged and that the flags start at zero. A line with an unknown stuck cell tells the two-write verify-and-retry path apart from the single-write path that a later write to the same line must take once the fault is cached. The stuck value is chosen opposite to the data bit, so the expected pattern is an inverted partition. A partition with two stuck cells of opposite demands separates a clean retry from the error case. Filling the cache past its size and then writing the evicted line shows that a partition without a known fault keeps its old flag, and requests raised while busy must leave memory untouched.

// File: rtl/siw_pkg.sv
package siw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_VREAD = 3'd2,
        ST_CHECK = 3'd3,
        ST_RREAD = 3'd4,
        ST_RCAP  = 3'd5
    } siw_state_e;
endpackage

// File: rtl/siw_fault_cache.sv
module siw_fault_cache #(
    parameter int LINE_W  = 64,
    parameter int PART_W  = 8,
    parameter int LINES   = 16,
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(LINES)-1:0]   lk_addr,
    input  logic [LINE_W-1:0]          lk_data,
    output logic [LINE_W/PART_W-1:0]   hit,
    output logic [LINE_W/PART_W-1:0]   need,
    output logic [LINE_W/PART_W-1:0]   conflict,
    input  logic                       ins_en,
    input  logic [$clog2(LINES)-1:0]   ins_addr,
    input  logic [$clog2(LINE_W)-1:0]  ins_pos,
    input  logic                       ins_val
);
    localparam int PARTS  = LINE_W / PART_W;
    localparam int POS_W  = $clog2(LINE_W);
    localparam int ADDR_W = $clog2(LINES);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q, vld_d;
    logic [ADDR_W-1:0]  line_q [ENTRIES];
    logic [ADDR_W-1:0]  line_d [ENTRIES];
    logic [POS_W-1:0]   pos_q  [ENTRIES];
    logic [POS_W-1:0]   pos_d  [ENTRIES];
    logic [ENTRIES-1:0] stk_q, stk_d;
    logic [IDX_W-1:0]   ptr_q, ptr_d;

    // lookup: the lowest matching entry decides, later ones may only disagree
    always_comb begin
        int  p;
        logic req;
        hit      = '0;
        need     = '0;
        conflict = '0;
        p        = 0;
        req      = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (vld_q[e] && (line_q[e] == lk_addr)) begin
                p   = int'(pos_q[e]) / PART_W;
                req = lk_data[pos_q[e]] ^ stk_q[e];
                if (!hit[p]) begin
                    hit[p]  = 1'b1;
                    need[p] = req;
                end else if (need[p] != req) begin
                    conflict[p] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        vld_d  = vld_q;
        line_d = line_q;
        pos_d  = pos_q;
        stk_d  = stk_q;
        ptr_d  = ptr_q;
        if (ins_en) begin
            vld_d[ptr_q]  = 1'b1;
            line_d[ptr_q] = ins_addr;
            pos_d[ptr_q]  = ins_pos;
            stk_d[ptr_q]  = ins_val;
            ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            stk_q <= '0;
            ptr_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                line_q[e] <= '0;
                pos_q[e]  <= '0;
            end
        end else begin
            vld_q  <= vld_d;
            stk_q  <= stk_d;
            ptr_q  <= ptr_d;
            line_q <= line_d;
            pos_q  <= pos_d;
        end
    end

    // R8
    ins_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (vld_q[$past(ptr_q)] && (pos_q[$past(ptr_q)] == $past(ins_pos))));

    // R8
    ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && (ENTRIES > 1)) |=> (ptr_q != $past(ptr_q)));

    logic unused_parts;
    assign unused_parts = (PARTS == 0);
endmodule

// File: rtl/siw_flag_store.sv
module siw_flag_store #(
    parameter int PARTS = 8,
    parameter int LINES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] addr,
    input  logic                     we,
    input  logic [PARTS-1:0]         wflags,
    output logic [PARTS-1:0]         rflags
);
    logic [PARTS-1:0] flags_q [LINES];
    logic [PARTS-1:0] flags_d [LINES];

    assign rflags = flags_q[addr];

    always_comb begin
        flags_d = flags_q;
        if (we) flags_d[addr] = wflags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) flags_q[l] <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // R3
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (flags_q[$past(addr)] == $past(rflags)));
endmodule

// File: rtl/stuck_inv_writer.sv
module stuck_inv_writer #(
    parameter int LINE_W     = 64,
    parameter int PART_W     = 8,
    parameter int LINES      = 16,
    parameter int FC_ENTRIES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_req,
    input  logic [$clog2(LINES)-1:0]  wr_addr,
    input  logic [LINE_W-1:0]         wr_data,
    input  logic                      rd_req,
    input  logic [$clog2(LINES)-1:0]  rd_addr,
    output logic                      busy,
    output logic                      wr_done,
    output logic                      wr_err,
    output logic                      rd_valid,
    output logic [LINE_W-1:0]         rd_data,
    output logic                      mem_we,
    output logic                      mem_re,
    output logic [$clog2(LINES)-1:0]  mem_addr,
    output logic [LINE_W-1:0]         mem_wdata,
    input  logic [LINE_W-1:0]         mem_rdata
);
    import siw_pkg::*;

    localparam int PARTS  = LINE_W / PART_W;
    localparam int POS_W  = $clog2(LINE_W);
    localparam int ADDR_W = $clog2(LINES);

    typedef struct packed {
        siw_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
        logic [LINE_W-1:0] enc;
        logic              retry;
        logic              err;
        logic              done;
        logic              rvld;
        logic [LINE_W-1:0] rdata;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [PARTS-1:0]  hit, need, conflict;
    logic [PARTS-1:0]  cur_flags, new_flags;
    logic [LINE_W-1:0] enc_new, mism;
    logic [POS_W-1:0]  low_pos;
    logic              ins_en, fs_we;

    function automatic logic [LINE_W-1:0] spread(input logic [PARTS-1:0] f);
        logic [LINE_W-1:0] r;
        for (int i = 0; i < LINE_W; i++) r[i] = f[i / PART_W];
        return r;
    endfunction

    siw_fault_cache #(
        .LINE_W (LINE_W),
        .PART_W (PART_W),
        .LINES  (LINES),
        .ENTRIES(FC_ENTRIES)
    ) cache_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (st_q.addr),
        .lk_data (st_q.data),
        .hit     (hit),
        .need    (need),
        .conflict(conflict),
        .ins_en  (ins_en),
        .ins_addr(st_q.addr),
        .ins_pos (low_pos),
        .ins_val (mem_rdata[low_pos])
    );

    siw_flag_store #(
        .PARTS(PARTS),
        .LINES(LINES)
    ) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (st_q.addr),
        .we    (fs_we),
        .wflags(new_flags),
        .rflags(cur_flags)
    );

    // per-partition flag choice
    for (genvar p = 0; p < PARTS; p++) begin : g_flag
        assign new_flags[p] = hit[p] ? need[p] : cur_flags[p];
    end

    assign enc_new = st_q.data ^ spread(new_flags);
    assign mism    = mem_rdata ^ st_q.enc;

    always_comb begin
        low_pos = '0;
        for (int i = LINE_W - 1; i >= 0; i--) begin
            if (mism[i]) low_pos = POS_W'(i);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rvld = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        fs_we     = 1'b0;
        ins_en    = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (wr_req) begin
                    st_d.state = ST_WRITE;
                    st_d.addr  = wr_addr;
                    st_d.data  = wr_data;
                    st_d.retry = 1'b0;
                    st_d.err   = 1'b0;
                end else if (rd_req) begin
                    st_d.state = ST_RREAD;
                    st_d.addr  = rd_addr;
                end
            end
            ST_WRITE: begin
                mem_we     = 1'b1;
                fs_we      = 1'b1;
                st_d.enc   = enc_new;
                st_d.err   = st_q.err | (|conflict);
                st_d.state = ST_VREAD;
            end
            ST_VREAD: begin
                mem_re     = 1'b1;
                st_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (mism == '0) begin
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end else if (!st_q.retry) begin
                    ins_en     = 1'b1;
                    st_d.retry = 1'b1;
                    st_d.state = ST_WRITE;
                end else begin
                    st_d.err   = 1'b1;
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end
            end
            ST_RREAD: begin
                mem_re     = 1'b1;
                st_d.state = ST_RCAP;
            end
            ST_RCAP: begin
                st_d.rdata = mem_rdata ^ spread(cur_flags);
                st_d.rvld  = 1'b1;
                st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = (st_q.state != ST_IDLE);
    assign wr_done   = st_q.done;
    assign wr_err    = st_q.err;
    assign rd_valid  = st_q.rvld;
    assign rd_data   = st_q.rdata;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = enc_new;

    // R5
    verify_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_re && $stable(mem_addr)));

    // R5
    rewrite_after_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> mem_we);

    // R9
    op_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(st_q.addr));

    // R4
    rd_valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_re, 2));

    // R1
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && rd_valid) && !(mem_we && mem_re));
endmodule

// File: tb/stuck_inv_writer_tb.sv
module stuck_inv_writer_tb_top;
    localparam int LW = 64;
    localparam int LN = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0, rd_req = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [LW-1:0] wr_data = '0;
    logic          busy, wr_done, wr_err, rd_valid, mem_we, mem_re;
    logic [LW-1:0] rd_data, mem_wdata;
    logic [LW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    logic [LW-1:0] marr  [LN];
    logic [LW-1:0] smask [LN];
    logic [LW-1:0] sval  [LN];
    int            we_total = 0;
    logic [LW-1:0] last_w = '0;
    int            checks = 0;
    int            errors = 0;

    always #5 clk = ~clk;

    stuck_inv_writer dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .wr_done(wr_done), .wr_err(wr_err),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // faulty memory model: reads see stuck cells
    always @(posedge clk) begin
        if (mem_we) begin
            marr[mem_addr] <= mem_wdata;
            we_total       <= we_total + 1;
            last_w         <= mem_wdata;
        end
        if (mem_re)
            mem_rdata <= (marr[mem_addr] & ~smask[mem_addr]) | (sval[mem_addr] & smask[mem_addr]);
    end

    task automatic chk(input string req, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [LW-1:0] d, output int nwr, output logic e);
        int start;
        int cnt;
        @(negedge clk);
        start   = we_total;
        wr_addr = a;
        wr_data = d;
        wr_req  = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        cnt    = 0;
        while (!wr_done && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        e   = wr_err;
        nwr = we_total - start;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [LW-1:0] d);
        int cnt;
        @(negedge clk);
        rd_addr = a;
        rd_req  = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        cnt    = 0;
        while (!rd_valid && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        d = rd_data;
    endtask

    task automatic t_reset();
        chk("R1", "busy", LW'(busy), '0);
        chk("R1", "wr_done", LW'(wr_done), '0);
        chk("R1", "wr_err", LW'(wr_err), '0);
        chk("R1", "rd_valid", LW'(rd_valid), '0);
        chk("R1", "mem strobes", LW'({mem_we, mem_re}), '0);
    endtask

    task automatic t_plain();
        int n; logic e; logic [LW-1:0] r;
        do_write(4'd0, 64'hDEAD_BEEF_0BAD_F00D, n, e);
        chk("R1", "plain wdata", last_w, 64'hDEAD_BEEF_0BAD_F00D);
        chk("R6", "plain writes", LW'(n), 64'd1);
        chk("R6", "plain err", LW'(e), '0);
        do_read(4'd0, r);
        chk("R4", "plain read", r, 64'hDEAD_BEEF_0BAD_F00D);
    endtask

    // line 1, bit 10 stuck at 1, data bit 10 is 0
    task automatic t_new_fault();
        int n; logic e; logic [LW-1:0] r;
        smask[1] = 64'h400;
        sval[1]  = 64'h400;
        do_write(4'd1, 64'h0123_4567_89AB_C0EF, n, e);
        chk("R5", "retry writes", LW'(n), 64'd2);
        chk("R2", "retry wdata", last_w, 64'h0123_4567_89AB_C0EF ^ 64'hFF00);
        chk("R5", "retry err", LW'(e), '0);
        do_read(4'd1, r);
        chk("R4", "inverted read", r, 64'h0123_4567_89AB_C0EF);
    endtask

    task automatic t_cached_fault();
        int n; logic e; logic [LW-1:0] r;
        do_write(4'd1, 64'hFEDC_BA98_7654_3000, n, e);
        chk("R6", "cached writes", LW'(n), 64'd1);
        chk("R2", "cached wdata", last_w, 64'hFEDC_BA98_7654_3000 ^ 64'hFF00);
        chk("R6", "cached err", LW'(e), '0);
        do_read(4'd1, r);
        chk("R4", "cached read", r, 64'hFEDC_BA98_7654_3000);
    endtask

    // line 2: bit 0 stuck at 1, bit 1 stuck at 0
    task automatic t_conflict();
        int n; logic e; logic [LW-1:0] r;
        smask[2] = 64'h3;
        sval[2]  = 64'h1;
        do_write(4'd2, 64'hA5A5_A5A5_A5A5_A5A2, n, e);
        chk("R5", "two-fault first writes", LW'(n), 64'd2);
        chk("R5", "two-fault first err", LW'(e), '0);
        do_read(4'd2, r);
        chk("R4", "two-fault read", r, 64'hA5A5_A5A5_A5A5_A5A2);
        do_write(4'd2, 64'h5A5A_5A5A_5A5A_5A58, n, e);
        chk("R7", "conflict err", LW'(e), 64'd1);
        chk("R7", "conflict writes", LW'(n), 64'd2);
        chk("R7", "conflict lower entry wins", last_w, 64'h5A5A_5A5A_5A5A_5A58 ^ 64'hFF);
    endtask

    // six more recorded faults overwrite the entry of line 1
    task automatic t_evict();
        int n; logic e; logic [LW-1:0] r;
        for (int k = 3; k <= 8; k++) begin
            smask[k] = 64'h10_0000;
            sval[k]  = 64'h10_0000;
            do_write(AW'(k), '0, n, e);
            chk("R5", "fill writes", LW'(n), 64'd2);
            chk("R8", "fill err", LW'(e), '0);
        end
        smask[1] = '0;
        do_write(4'd1, 64'h1111_2222_3333_4444, n, e);
        chk("R8", "evicted writes", LW'(n), 64'd1);
        chk("R3", "flag kept wdata", last_w, 64'h1111_2222_3333_4444 ^ 64'hFF00);
        do_read(4'd1, r);
        chk("R3", "flag kept read", r, 64'h1111_2222_3333_4444);
    endtask

    task automatic t_busy_ignore();
        int start; int cnt; logic [LW-1:0] r;
        @(negedge clk);
        start   = we_total;
        wr_addr = 4'd9;
        wr_data = 64'h0F0F_1234_5678_F0F0;
        wr_req  = 1'b1;
        @(negedge clk);
        chk("R9", "busy raised", LW'(busy), 64'd1);
        wr_addr = 4'd0;
        wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        rd_addr = 4'd0;
        rd_req  = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        rd_req = 1'b0;
        cnt    = 0;
        while (!wr_done && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        chk("R9", "writes during busy", LW'(we_total - start), 64'd1);
        @(negedge clk);
        chk("R9", "no stray read", LW'(rd_valid), '0);
        do_read(4'd0, r);
        chk("R9", "line 0 untouched", r, 64'hDEAD_BEEF_0BAD_F00D);
        do_read(4'd9, r);
        chk("R4", "line 9 read", r, 64'h0F0F_1234_5678_F0F0);
    endtask

    initial begin
        for (int l = 0; l < LN; l++) begin
            smask[l] = '0;
            sval[l]  = '0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_new_fault();
        t_cached_fault();
        t_conflict();
        t_evict();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule